// File: doc/BRIEF.md
# Clocked-Address Byte-Wide Program Memory Port

This block is the device-side port that a programmer uses to load and read back a one-time program memory of 16-bit words. There is no address bus. An internal byte address starts at zero and moves forward only when an external address clock is pulsed. Each group of four pulses advances it by one byte. The step happens on the falling edge of the third pulse of the group. Every 16-bit word appears as two bytes: the upper half at the even byte address and the lower half at the following odd address.

A 2-bit mode input selects one of four operations. Clear forces the address and the pulse phase to zero. Inhibit holds the memory untouched. Write accepts bytes over a valid/ready input stream. Verify presents the byte at the current address on an output stream whose valid flag also serves as the bus drive enable. Outside verify the output is not driven.

Back-pressure rules: `in_ready` is high exactly while the mode is write. A byte transfers on every system clock edge where both `in_valid` and `in_ready` are high. Holding `in_valid` for several cycles repeats the same transfer, and because programming can only clear bits, the repeats do nothing further. The output stream has no ready: `out_valid` is held for as long as verify mode lasts, and the consumer samples `out_data` whenever it needs to. The address clock is asynchronous. It is synchronised into the system clock, so each of its high and low phases must last at least three system clock cycles. The memory size is the parameter `WORDS`. The full part uses 12160 words. The default stays small so that elaboration is light.

Top module: `prom_byte_port`

## Requirements
- R1: With `mode` = 2'b00 (clear), the byte address and the pulse phase return to zero. After leaving clear, the next pulses start a fresh group of four.
- R2: Outside clear, the byte address advances by exactly one per four falling edges of `addr_clk`, at the third falling edge of each group. The first and second falling edges of a group leave it unchanged.
- R3: Pulses of `addr_clk` while `mode` = 2'b00 have no effect on the address.
- R4: `out_valid` is high exactly while `mode` = 2'b11 (verify). `out_data` is 8'h00 whenever `out_valid` is low.
- R5: In verify mode, `out_data` is the stored byte at the current byte address. Even byte address 2k is the upper 8 bits of word k, and odd byte address 2k+1 is its lower 8 bits.
- R6: `in_ready` is high exactly while `mode` = 2'b10 (write). A transfer replaces the addressed byte with the bitwise AND of its old value and `in_data`, so bits only go from 1 to 0.
- R7: `in_valid` has no effect on stored data in clear, inhibit (2'b01) or verify mode.
- R8: After reset, every stored byte reads 8'hFF (erased).
- R9: The byte address saturates at 2*WORDS-1, and pulses beyond it leave it there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; erases the array |
| addr_clk | input | 1 | External address-step clock, asynchronous |
| mode | input | 2 | 00 clear, 01 inhibit, 10 write, 11 verify |
| in_valid | input | 1 | Write byte offered |
| in_ready | output | 1 | Port accepts a write byte (write mode) |
| in_data | input | 8 | Byte to program |
| out_valid | output | 1 | Read byte presented; bus drive enable |
| out_data | output | 8 | Byte at the current address |

## Verification
The assertions check four things on every cycle. The address only ever holds, steps by one, or returns to zero, and a step happens only as the phase enters its last quarter. Clear zeroes the counters on the next cycle, and the address never passes the last byte. A write can only clear bits, and with no write and no address change the stored byte stays put. Three things can only be shown by the bench's scenarios. The first is the group-of-four cadence and where the step falls within a group. The second is the word-to-byte layout across a full sweep with saturation at the end. The third is that stray write strobes and pulses in the wrong mode leave no trace, which shows up when the array is read back.

// File: rtl/prom_port_pkg.sv
package prom_port_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR   = 2'b00,
    MODE_INHIBIT = 2'b01,
    MODE_WRITE   = 2'b10,
    MODE_VERIFY  = 2'b11
  } port_mode_e;

  localparam int unsigned GROUP_PULSES = 4;
  localparam int unsigned STEP_PHASE   = 2;  // zero-based index of stepping pulse
endpackage

// File: rtl/prom_clk_sync.sv
module prom_clk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign fall_pulse = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/prom_addr_seq.sv
module prom_addr_seq
  import prom_port_pkg::*;
#(
  parameter int unsigned WORDS  = 1024,
  localparam int unsigned BYTES  = 2 * WORDS,
  localparam int unsigned ADDR_W = $clog2(BYTES),
  localparam int unsigned PH_W   = $clog2(GROUP_PULSES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_mode_e        mode,
  input  logic              step_fall,
  output logic [ADDR_W-1:0] byte_addr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BYTES - 1);
  localparam logic [PH_W-1:0]   STEP_PH   = PH_W'(STEP_PHASE);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      byte_addr <= '0;
    end else if (mode == MODE_CLEAR) begin
      phase     <= '0;
      byte_addr <= '0;
    end else if (step_fall) begin
      phase <= phase + 1'b1;
      if (phase == STEP_PH && byte_addr != LAST_ADDR)
        byte_addr <= byte_addr + 1'b1;
    end
  end

  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_CLEAR |=> (byte_addr == '0 && phase == '0));
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_addr != $past(byte_addr) |-> (byte_addr == $past(byte_addr) + 1'b1 || byte_addr == '0));
  a_r2_step_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_addr != $past(byte_addr) && byte_addr != '0) |-> phase == STEP_PH + 1'b1);
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    byte_addr <= LAST_ADDR);
endmodule

// File: rtl/prom_byte_array.sv
module prom_byte_array #(
  parameter int unsigned WORDS  = 1024,
  localparam int unsigned ADDR_W = $clog2(2 * WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_byte,
  output logic [7:0]        rd_byte
);
  logic [15:0]       mem [WORDS];
  logic [ADDR_W-2:0] word_idx;
  logic              low_half;

  assign word_idx = byte_addr[ADDR_W-1:1];
  assign low_half = byte_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (wr_en) begin
      if (low_half) mem[word_idx][7:0]  <= mem[word_idx][7:0]  & wr_byte;
      else          mem[word_idx][15:8] <= mem[word_idx][15:8] & wr_byte;
    end
  end

  assign rd_byte = low_half ? mem[word_idx][7:0] : mem[word_idx][15:8];

  a_r6_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $stable(byte_addr)) |-> (rd_byte & ~$past(rd_byte)) == 8'h00);
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && $stable(byte_addr)) |-> $stable(rd_byte));
endmodule

// File: rtl/prom_byte_port.sv
module prom_byte_port
  import prom_port_pkg::*;
#(
  parameter int unsigned WORDS       = 1024,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(2 * WORDS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_clk,
  input  logic [1:0] mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  output logic [7:0] out_data
);
  port_mode_e        mode_e;
  logic              fall;
  logic [ADDR_W-1:0] byte_addr;
  logic [7:0]        rd_byte;
  logic              wr_en;

  assign mode_e = port_mode_e'(mode);

  prom_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(addr_clk), .fall_pulse(fall)
  );

  prom_addr_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .step_fall(fall), .byte_addr(byte_addr)
  );

  assign in_ready = (mode_e == MODE_WRITE);
  assign wr_en    = in_valid & in_ready;

  prom_byte_array #(.WORDS(WORDS)) u_array (
    .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr),
    .wr_en(wr_en), .wr_byte(in_data), .rd_byte(rd_byte)
  );

  assign out_valid = (mode_e == MODE_VERIFY);
  assign out_data  = out_valid ? rd_byte : 8'h00;

  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == 8'h00);
  a_r6_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

// File: tb/tb_prom_byte_port.sv
module tb_prom_byte_port;
  localparam int WORDS = 4;
  localparam int BYTES = 2 * WORDS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_clk = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  prom_byte_port #(.WORDS(WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .addr_clk(addr_clk), .mode(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // behavioural model
  logic [7:0] m_mem [BYTES];
  int m_addr = 0, m_phase = 0;
  int settle = 0;
  int checks = 0, fails = 0;
  string tag = "R8";
  bit done = 0;

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (settle >= 4) begin
        chk("R4 valid", out_valid, mode == 2'b11);
        chk("R6 ready", in_ready, mode == 2'b10);
        chk({tag, " data"}, out_data, (mode == 2'b11) ? m_mem[m_addr] : 8'h00);
      end
      settle++;
    end
  end

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    if (m == 2'b00) begin m_addr = 0; m_phase = 0; end
    settle = 0;
  endtask

  task automatic pulse();
    @(negedge clk); addr_clk = 1'b1; settle = 0;
    repeat (4) @(negedge clk);
    addr_clk = 1'b0; settle = 0;
    if (mode != 2'b00) begin
      if (m_phase == 2 && m_addr != BYTES - 1) m_addr++;
      m_phase = (m_phase + 1) % 4;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d; settle = 0;
    if (mode == 2'b10) m_mem[m_addr] &= d;
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < BYTES; i++) m_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: erased contents after reset, walk the array in verify
    tag = "R8";
    set_mode(2'b00); set_mode(2'b11); wait_cyc(6);
    for (int i = 0; i < BYTES * 4; i++) pulse();
    // R6/R2/R9: program each byte, stepping with groups of four
    tag = "R6";
    set_mode(2'b00); set_mode(2'b10); wait_cyc(6);
    for (int i = 0; i < BYTES + 2; i++) begin
      wr(8'h50 + 8'(i) * 8'h11);
      for (int p = 0; p < 4; p++) pulse();
    end
    // R9: saturation at last byte, verify it is still the last one
    tag = "R9";
    set_mode(2'b11); wait_cyc(6);
    chk("R9 saturated addr", m_addr, BYTES - 1);
    // R5: read back from zero, even=upper, odd=lower of each word
    tag = "R5";
    set_mode(2'b00); set_mode(2'b11); wait_cyc(6);
    for (int i = 0; i < BYTES * 4; i++) pulse();
    // R2: first two falls leave address, third steps it
    tag = "R2";
    set_mode(2'b00); set_mode(2'b11); wait_cyc(6);
    pulse(); pulse(); wait_cyc(4);
    chk("R2 after two falls", m_addr, 0);
    pulse(); wait_cyc(4);
    chk("R2 after third fall", m_addr, 1);
    // R1: clear mid-group restarts phase
    tag = "R1";
    set_mode(2'b00); set_mode(2'b11); wait_cyc(6);
    pulse(); pulse(); set_mode(2'b00); set_mode(2'b11); wait_cyc(6);
    pulse(); pulse(); wait_cyc(4);
    chk("R1 phase restarted", m_addr, 0);
    // R3: pulses during clear are ignored
    tag = "R3";
    set_mode(2'b00);
    for (int i = 0; i < 8; i++) pulse();
    set_mode(2'b11); wait_cyc(6);
    chk("R3 addr after clear pulses", m_addr, 0);
    // R7: strobes in inhibit, verify and clear leave memory
    tag = "R7";
    set_mode(2'b01); wr(8'h00);
    set_mode(2'b11); wr(8'h00);
    set_mode(2'b00); wr(8'h00);
    set_mode(2'b11); wait_cyc(6);
    for (int i = 0; i < 8; i++) pulse();
    // R6: rewrite only clears more bits
    tag = "R6";
    set_mode(2'b00); set_mode(2'b10); wr(8'hF0); wr(8'h0F);
    set_mode(2'b11); wait_cyc(6);
    chk("R6 cumulative AND", out_data, 8'h00);
    wait_cyc(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule